// File: doc/BRIEF.md
# Byte-Select SRAM Bus Controller

This block runs one chip-select space that is wired to a 16-bit asynchronous static RAM. The RAM has one select pin for the upper byte and one for the lower byte. A host hands over a single request at a time: address, direction, two byte enables and write data. The controller then plays out the access on the memory pins: chip select, read strobe, read/write line, the two byte-select strobes and the enable for the data-bus output driver. When the access ends it returns the read data together with a one-cycle done pulse.

A mode input picks one of two strobe schemes.

- **Mode 0:** the byte selects act as the write strobes, so a write looks like an ordinary asynchronous write. The byte selects are also pulsed on reads.
- **Mode 1:** the byte selects stay low for the whole access, and the read/write line carries the write strobe. A programmable number of hold cycles follows the strobe, during which data and byte selects remain valid.

Both schemes insert a programmable number of wait cycles, and an external active-low wait pin can stretch them further.

Each access has the phases T1, then zero or more Tw, then T2, then (mode 1 writes only) hold cycles. T1 sets up the address and chip select. Tw are the wait cycles. T2 ends the strobe. The mode, wait count and hold count are taken at the clock edge that accepts the request.

Top module: `bytesel_sram_ctrl`

## Requirements
- R1: In reset and whenever idle, mem_cs_n, mem_rd_n, mem_rdwr_n and both mem_bs_n bits are 1, mem_dq_oe is 0, req_ready is 1 and rsp_done is 0.
- R2: A request accepted at a clock edge gives one T1 cycle, then W Tw cycles (W = cfg_wait), then one T2 cycle, then the hold cycles. mem_cs_n is 0 and mem_addr equals the request address in all of these cycles.
- R3: Mode 0 write (cfg_mode=0, req_we=1):
  - mem_rdwr_n is 0 from T1 through T2.
  - mem_bs_n[1] (upper byte, req_be[1]) and mem_bs_n[0] (lower byte, req_be[0]) are 0 only during Tw and T2, and only for enabled bytes.
  - There are no hold cycles, whatever cfg_hold is.
- R4: Mode 0 read: mem_rd_n is 0 and the enabled mem_bs_n bits are 0 during Tw and T2. mem_rdwr_n stays 1.
- R5: Mode 1 write:
  - The enabled mem_bs_n bits are 0 from T1 through the last hold cycle.
  - mem_rdwr_n is 0 only during Tw and T2.
  - H hold cycles follow T2 (H = cfg_hold, 0 to 3). In them mem_cs_n stays 0, mem_rdwr_n is 1 and the data stays driven.
- R6: Mode 1 read: the enabled mem_bs_n bits are 0 from T1 through T2, mem_rd_n is 0 during Tw and T2, and there are no hold cycles.
- R7: mem_dq_oe is 1 in every cycle of a write access and 0 otherwise, and mem_dq_out then equals the request write data.
- R8: mem_wait_n is sampled only in the last programmed Tw cycle. Each cycle it is 0 there adds one more Tw. It has no effect in T1, in earlier Tw cycles, or when cfg_wait is 0.
- R9: rsp_rdata takes mem_dq_in at the clock edge that ends T2. rsp_done is 1 for exactly the single idle cycle that follows the last cycle of the access, and rsp_rdata is valid in that cycle.
- R10: A request is accepted only while req_ready is 1. req_valid held high during an access starts nothing and changes nothing.
- R11: Changes to cfg_mode, cfg_wait or cfg_hold after acceptance do not affect the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Strobe scheme: 0 byte selects strobe, 1 read/write line strobes |
| cfg_wait | input | WAIT_W | Programmed Tw cycles |
| cfg_hold | input | HOLD_W | Hold cycles after a mode 1 write strobe |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Request address |
| req_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | 16 | Captured read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_rdwr_n | output | 1 | Read/write line, low for write |
| mem_bs_n | output | 2 | Byte selects, active low, bit 1 upper |
| mem_dq_out | output | 16 | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_in | input | 16 | Data bus input value |
| mem_wait_n | input | 1 | External wait, active low |

## Verification
The bound checker watches several rules on every cycle:

- While idle, every strobe is inactive.
- No strobe or byte select appears without chip select.
- The read strobe never coincides with a low read/write line or with the output enable.
- The address holds steady during an access.
- Done is a single pulse that follows a busy cycle.

Only the bench scenarios can show the rest: exact counts of Tw and hold cycles, the window of each strobe in each mode and direction, the extra waits from the wait pin, the edge at which read data is taken, and the latching of configuration at acceptance.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    localparam int BYTES  = 2;
    localparam int DATA_W = 8 * BYTES;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_TW   = 3'd2,
        PH_T2   = 3'd3,
        PH_HOLD = 3'd4
    } phase_e;
endpackage

// File: rtl/bsram_seq.sv
module bsram_seq
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int WAIT_W = 4,
    parameter int HOLD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_mode,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              mem_wait_n,
    input  logic [DATA_W-1:0] mem_dq_in,
    output phase_e            phase,
    output logic              acc_we,
    output logic [BYTES-1:0]  acc_be,
    output logic              acc_mode,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    typedef struct packed {
        phase_e              ph;
        logic [WAIT_W-1:0]   wcnt;
        logic [HOLD_W-1:0]   hcnt;
        logic                we;
        logic [BYTES-1:0]    be;
        logic                mode;
        logic [WAIT_W-1:0]   wcfg;
        logic [HOLD_W-1:0]   hcfg;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic                done;
    } seq_t;

    seq_t r_d, r_q;
    logic [WAIT_W:0] wnext;
    logic [HOLD_W:0] hnext;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        wnext    = {1'b0, r_q.wcnt} + (WAIT_W+1)'(1);
        hnext    = {1'b0, r_q.hcnt} + (HOLD_W+1)'(1);
        unique case (r_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    r_d.ph    = PH_T1;
                    r_d.we    = req_we;
                    r_d.be    = req_be;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.mode  = cfg_mode;
                    r_d.wcfg  = cfg_wait;
                    r_d.hcfg  = cfg_hold;
                    r_d.wcnt  = '0;
                    r_d.hcnt  = '0;
                end
            end
            PH_T1: begin
                r_d.ph = (r_q.wcfg == '0) ? PH_T2 : PH_TW;
            end
            PH_TW: begin
                if (wnext < {1'b0, r_q.wcfg}) begin
                    r_d.wcnt = wnext[WAIT_W-1:0];
                end else if (mem_wait_n) begin
                    r_d.ph = PH_T2;
                end
            end
            PH_T2: begin
                if (!r_q.we) begin
                    r_d.rdata = mem_dq_in;
                end
                if (r_q.we && r_q.mode && (r_q.hcfg != '0)) begin
                    r_d.ph = PH_HOLD;
                end else begin
                    r_d.ph   = PH_IDLE;
                    r_d.done = 1'b1;
                end
            end
            PH_HOLD: begin
                if (hnext < {1'b0, r_q.hcfg}) begin
                    r_d.hcnt = hnext[HOLD_W-1:0];
                end else begin
                    r_d.ph   = PH_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign phase     = r_q.ph;
    assign acc_we    = r_q.we;
    assign acc_be    = r_q.be;
    assign acc_mode  = r_q.mode;
    assign acc_addr  = r_q.addr;
    assign acc_wdata = r_q.wdata;
    assign rd_data   = r_q.rdata;
    assign done      = r_q.done;
endmodule

// File: rtl/bsram_pins.sv
module bsram_pins
    import bsram_pkg::*;
(
    input  phase_e           phase,
    input  logic             acc_we,
    input  logic             acc_mode,
    input  logic [BYTES-1:0] acc_be,
    output logic             idle,
    output logic             cs_n,
    output logic             rd_n,
    output logic             rdwr_n,
    output logic [BYTES-1:0] bs_n,
    output logic             dq_oe
);
    logic active;
    logic strobe;
    logic wr_win;
    logic bs_on;

    always_comb begin
        active = (phase != PH_IDLE);
        strobe = (phase == PH_TW) || (phase == PH_T2);
        wr_win = acc_mode ? strobe : (strobe || (phase == PH_T1));
        bs_on  = acc_mode ? active : strobe;
        idle   = !active;
        cs_n   = !active;
        rd_n   = !(!acc_we && strobe);
        rdwr_n = !(acc_we && wr_win);
        dq_oe  = acc_we && active;
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_bs
        assign bs_n[b] = !(acc_be[b] && bs_on);
    end
endmodule

// File: rtl/bytesel_sram_ctrl.sv
module bytesel_sram_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int WAIT_W = 4,
    parameter int HOLD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [15:0]       req_wdata,
    output logic              rsp_done,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_rdwr_n,
    output logic [1:0]        mem_bs_n,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in,
    input  logic              mem_wait_n
);
    phase_e           phase;
    logic             acc_we;
    logic             acc_mode;
    logic [BYTES-1:0] acc_be;
    logic             seq_req_valid;

    assign seq_req_valid = req_valid && req_ready;

    bsram_seq #(
        .ADDR_W(ADDR_W),
        .WAIT_W(WAIT_W),
        .HOLD_W(HOLD_W)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (seq_req_valid),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .cfg_mode  (cfg_mode),
        .cfg_wait  (cfg_wait),
        .cfg_hold  (cfg_hold),
        .mem_wait_n(mem_wait_n),
        .mem_dq_in (mem_dq_in),
        .phase     (phase),
        .acc_we    (acc_we),
        .acc_be    (acc_be),
        .acc_mode  (acc_mode),
        .acc_addr  (mem_addr),
        .acc_wdata (mem_dq_out),
        .rd_data   (rsp_rdata),
        .done      (rsp_done)
    );

    bsram_pins i_pins (
        .phase   (phase),
        .acc_we  (acc_we),
        .acc_mode(acc_mode),
        .acc_be  (acc_be),
        .idle    (req_ready),
        .cs_n    (mem_cs_n),
        .rd_n    (mem_rd_n),
        .rdwr_n  (mem_rdwr_n),
        .bs_n    (mem_bs_n),
        .dq_oe   (mem_dq_oe)
    );
endmodule

// File: rtl/bsram_checker.sv
module bsram_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              mem_cs_n,
    input logic              mem_rd_n,
    input logic              mem_rdwr_n,
    input logic [1:0]        mem_bs_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_rd_n && mem_rdwr_n && (mem_bs_n == 2'b11) && !mem_dq_oe));

    p_strobe_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_rdwr_n || (mem_bs_n != 2'b11)) |-> !mem_cs_n);

    p_addr_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(mem_addr));

    p_read_not_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> mem_rdwr_n);

    p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !mem_dq_oe);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (req_ready && !$past(req_ready)));
endmodule

bind bytesel_sram_ctrl bsram_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .mem_rdwr_n(mem_rdwr_n),
    .mem_bs_n  (mem_bs_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr)
);

// File: tb/test_bytesel_sram_ctrl.sv
`timescale 1ns/1ps
module test_bytesel_sram_ctrl;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_mode = 1'b0;
    logic [3:0]    cfg_wait = '0;
    logic [1:0]    cfg_hold = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_be = '0;
    logic [15:0]   req_wdata = '0;
    logic          rsp_done;
    logic [15:0]   rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_rd_n, mem_rdwr_n, mem_dq_oe;
    logic [1:0]    mem_bs_n;
    logic [15:0]   mem_dq_out;
    logic [15:0]   mem_dq_in = '0;
    logic          mem_wait_n = 1'b1;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bytesel_sram_ctrl #(.ADDR_W(AW), .WAIT_W(4), .HOLD_W(2)) i_bytesel_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_rdwr_n(mem_rdwr_n),
        .mem_bs_n(mem_bs_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_wait_n(mem_wait_n)
    );

    typedef struct {
        bit          cs_n, rd_n, rdwr_n;
        bit [1:0]    bs_n;
        bit          oe, ready, done, chk_rd;
        logic [15:0] rd_exp;
        bit          wait_drv;
        logic [15:0] dq_drv;
        string       tag;
    } rec_t;

    rec_t q[$];
    logic [AW-1:0] cur_addr;
    logic [15:0]   cur_wdata;

    function automatic rec_t mk(bit cs_n, bit rd_n, bit rdwr_n, bit [1:0] bs_n, bit oe,
                                bit ready, bit done, bit chk, logic [15:0] rde,
                                bit wd, logic [15:0] dqd, string tg);
        rec_t r;
        r.cs_n = cs_n; r.rd_n = rd_n; r.rdwr_n = rdwr_n; r.bs_n = bs_n; r.oe = oe;
        r.ready = ready; r.done = done; r.chk_rd = chk; r.rd_exp = rde;
        r.wait_drv = wd; r.dq_drv = dqd; r.tag = tg;
        return r;
    endfunction

    task automatic check(string tag, string name, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic check_rec(rec_t r);
        check({r.tag, "/R2"}, "mem_cs_n", int'(mem_cs_n), int'(r.cs_n));
        check(r.tag, "mem_rd_n", int'(mem_rd_n), int'(r.rd_n));
        check(r.tag, "mem_rdwr_n", int'(mem_rdwr_n), int'(r.rdwr_n));
        check(r.tag, "mem_bs_n", int'(mem_bs_n), int'(r.bs_n));
        check({r.tag, "/R7"}, "mem_dq_oe", int'(mem_dq_oe), int'(r.oe));
        check({r.tag, "/R10"}, "req_ready", int'(req_ready), int'(r.ready));
        check(r.tag, "rsp_done", int'(rsp_done), int'(r.done));
        if (!r.cs_n) check({r.tag, "/R2"}, "mem_addr", int'(mem_addr), int'(cur_addr));
        if (r.oe) check({r.tag, "/R7"}, "mem_dq_out", int'(mem_dq_out), int'(cur_wdata));
        if (r.chk_rd) check({r.tag, "/R9"}, "rsp_rdata", int'(rsp_rdata), int'(r.rd_exp));
    endtask

    // Expected cycle-by-cycle schedule taken from the requirements.
    task automatic build(bit we, bit [1:0] be, bit mode, int w, int h, int extra,
                         logic [15:0] rdq, string tg);
        int ntw;
        int nh;
        q.delete();
        ntw = (w == 0) ? 0 : w + extra;
        nh  = (we && mode) ? h : 0;
        q.push_back(mk(0, 1, we ? mode : 1'b1, mode ? ~be : 2'b11, we, 0, 0, 0, '0,
                       1'b0, ~rdq, tg));
        for (int i = 0; i < ntw; i++) begin
            q.push_back(mk(0, we, !we, ~be, we, 0, 0, 0, '0,
                           (i < w - 1 + extra) ? 1'b0 : 1'b1, ~rdq, (i >= w) ? "R8" : tg));
        end
        q.push_back(mk(0, we, !we, ~be, we, 0, 0, 0, '0, 1'b1, rdq, tg));
        for (int i = 0; i < nh; i++) begin
            q.push_back(mk(0, 1, 1, ~be, 1, 0, 0, 0, '0, 1'b1, ~rdq, "R5"));
        end
        q.push_back(mk(1, 1, 1, 2'b11, 0, 1, 1, !we, rdq, 1'b1, ~rdq, "R9"));
    endtask

    task automatic run(bit we, bit [1:0] be, bit mode, int w, int h, int extra,
                       logic [AW-1:0] a, logic [15:0] wd, logic [15:0] rdq,
                       bit busy_req, bit cfg_flip, string tg);
        rec_t r;
        bit first;
        @(negedge clk);
        check_rec(mk(1, 1, 1, 2'b11, 0, 1, 0, 0, '0, 1'b1, '0, "R1"));
        cur_addr  = a;
        cur_wdata = wd;
        req_valid = 1'b1; req_we = we; req_be = be; req_addr = a; req_wdata = wd;
        cfg_mode = mode; cfg_wait = 4'(w); cfg_hold = 2'(h);
        mem_wait_n = 1'b1;
        build(we, be, mode, w, h, extra, rdq, tg);
        first = 1'b1;
        while (q.size() > 0) begin
            @(negedge clk);
            r = q.pop_front();
            check_rec(r);
            if (first) begin
                if (busy_req) begin
                    req_we = !we; req_addr = ~a; req_wdata = ~wd; req_be = ~be;
                end else begin
                    req_valid = 1'b0;
                end
                if (cfg_flip) begin
                    cfg_mode = !mode; cfg_wait = ~4'(w); cfg_hold = ~2'(h);
                end
                first = 1'b0;
            end
            mem_wait_n = r.wait_drv;
            mem_dq_in  = r.dq_drv;
            if (q.size() == 0) req_valid = 1'b0;
        end
        mem_wait_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_rec(mk(1, 1, 1, 2'b11, 0, 1, 0, 0, '0, 1'b1, '0, "R1"));
        rst_n = 1'b1;
        run(1, 2'b11, 0, 2, 0, 0, 20'h12345, 16'hA55A, 16'h0000, 0, 0, "R3");
        run(0, 2'b01, 0, 0, 0, 0, 20'h00010, 16'h0000, 16'h1234, 0, 0, "R4");
        run(0, 2'b10, 0, 3, 0, 2, 20'h0ABCD, 16'h0000, 16'hBEEF, 0, 0, "R4");
        run(1, 2'b10, 1, 1, 3, 0, 20'hF0F0F, 16'h7E81, 16'h0000, 0, 0, "R5");
        run(1, 2'b11, 1, 0, 0, 0, 20'h00001, 16'hC3C3, 16'h0000, 0, 0, "R5");
        run(0, 2'b11, 1, 2, 3, 0, 20'h55555, 16'h0000, 16'h9876, 0, 0, "R6");
        run(1, 2'b11, 0, 0, 0, 3, 20'h00300, 16'h0F0F, 16'h0000, 0, 0, "R8");
        run(1, 2'b01, 1, 4, 2, 0, 20'hAAAAA, 16'h1357, 16'h0000, 1, 0, "R10");
        run(0, 2'b11, 0, 1, 0, 0, 20'h0CAFE, 16'h0000, 16'h4242, 0, 1, "R11");
        run(1, 2'b01, 1, 15, 1, 1, 20'hFFFFF, 16'hFFFF, 16'h0000, 0, 0, "R8");
        run(1, 2'b10, 0, 1, 3, 0, 20'h07070, 16'h2468, 16'h0000, 0, 0, "R3");
        @(negedge clk);
        check_rec(mk(1, 1, 1, 2'b11, 0, 1, 0, 0, '0, 1'b1, '0, "R1"));
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule